// File: doc/BRIEF.md
# SDRAM Device-Side Burst Engine with Auto-Precharge

This block is the command and burst core on the memory side of a four-bank synchronous DRAM. Each clock edge it registers one command: no-op, bank activate, read, write or mode load. Reads and writes carry an auto-precharge flag. The engine keeps a state for every bank and walks the columns of each burst. Read beats reach the data port through a CAS-latency pipeline. Write beats are reported as a strobe with a column and a bank, one per beat. The storage array, refresh and power-down sit outside this block.

A read or write to a different bank may cut short a burst that has auto-precharge set. The interrupted bank then starts its precharge at once, or starts its write-back if it was writing. A new read lets the old read's data drain, so the new data follows with no gap. A new write drops the old read data in the cycle after it is registered, and the engine flags bus contention if the data mask was not raised three edges earlier. The mode register has a single-write option. With it set, every write touches one column, while reads keep the programmed burst length.

Top module: `sdram_burst_engine`

## Requirements
- R1: After reset all four banks report idle, no read or write beat is presented and both flags are low. Command codes on `cmd` are: 0 no-op, 1 activate, 2 read, 3 write, 4 mode load. Other codes act as no-op.
- R2: An activate to an idle bank makes that bank leave idle. An activate to a bank that is not idle, and a read or write to a bank that is not plainly active, has no effect and pulses `illegal_cmd` in the cycle after its edge.
- R3: A mode load takes the burst length code from address bits 2:0 (0..3 give lengths 1, 2, 4, 8), the CAS latency from bits 6:4 (1 to 3), and the single-write bit from bit 9. It is accepted only when all banks are idle and no burst or read data is in flight, and only with legal field values. Otherwise it is ignored and flagged on `illegal_cmd`.
- R4: A read registered at edge k puts `rd_oe` high from the cycle after edge k+CL-1 for exactly burst-length cycles. This holds whatever the single-write bit is.
- R5: The columns of a burst advance by one and wrap inside the block that is aligned to the burst length and contains the start column.
- R6: A write registered at edge k presents `wr_en` from the cycle after edge k, for the burst length, or for one beat when the single-write bit is 1.
- R7: A read to another bank registered at edge k while an auto-precharge read is bursting ends the old bank's beats. Its data still drains through the latency pipeline, so the new data follows without a gap. The old bank's `pre_start` pulses in the cycle after edge k.
- R8: A write registered at edge k while read data is in flight drops `rd_oe` from the cycle after edge k. An auto-precharge read bank it cuts short pulses `pre_start` in that same cycle.
- R9: `contention_err` pulses in the cycle after a write edge k exactly when read beats were still in flight at k and `dqm` was low at edge k-3.
- R10: An uninterrupted auto-precharge read of length L registered at edge k pulses `pre_start` in the cycle after edge k+L.
- R11: An auto-precharge write whose last beat is captured at edge e holds `wb_busy` for TDPL cycles after edge e+1. `pre_start` then pulses in the cycle after edge e+1+TDPL.
- R12: A bank reports idle again TRP edges after the edge where its precharge starts.
- R13: While a bank is committed to auto-precharge, writing back or precharging, any command to it is ignored and flagged. An ignored command leaves the running burst and the return to idle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code sampled each edge |
| cmd_bank | input | 2 | Target bank |
| cmd_addr | input | 10 | Start column, or mode fields on a mode load |
| cmd_ap | input | 1 | Auto-precharge request on read or write |
| dqm | input | 1 | Data mask input, watched for bus turnaround |
| rd_oe | output | 1 | Read data output enable |
| rd_bank | output | 2 | Bank of the current read beat |
| rd_col | output | 10 | Column of the current read beat |
| wr_en | output | 1 | Write beat strobe |
| wr_bank | output | 2 | Bank of the current write beat |
| wr_col | output | 10 | Column of the current write beat |
| pre_start | output | 4 | One-cycle pulse per bank when its precharge starts |
| wb_busy | output | 4 | Per bank, write-back interval in progress |
| bank_idle | output | 4 | Per bank, idle |
| contention_err | output | 1 | Pulse on a read-to-write turnaround without the mask |
| illegal_cmd | output | 1 | Pulse when a command is ignored |

## Verification
A wrong bank state shows at the ports within one cycle, as a missing or false `illegal_cmd`. It also shows some cycles later, when `pre_start` or `bank_idle` appears at the wrong edge. A broken burst counter or wrap mask shows on the first bad beat as a wrong `rd_col` or `wr_col`, or as `rd_oe` or `wr_en` held one cycle too many or too few. A wrong latency stage moves the whole read window by whole cycles. A bad mask history changes `contention_err` on the very write that interrupts the read.

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine #(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 10,
  parameter int MAX_CL = 3,
  parameter int TRP    = 3,
  parameter int TDPL   = 2
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               cmd,
  input  logic [$clog2(BANKS)-1:0] cmd_bank,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic                     cmd_ap,
  input  logic                     dqm,
  output logic                     rd_oe,
  output logic [$clog2(BANKS)-1:0] rd_bank,
  output logic [ADDR_W-1:0]        rd_col,
  output logic                     wr_en,
  output logic [$clog2(BANKS)-1:0] wr_bank,
  output logic [ADDR_W-1:0]        wr_col,
  output logic [BANKS-1:0]         pre_start,
  output logic [BANKS-1:0]         wb_busy,
  output logic [BANKS-1:0]         bank_idle,
  output logic                     contention_err,
  output logic                     illegal_cmd
);
  localparam int BW   = $clog2(BANKS);
  localparam int CLW  = $clog2(MAX_CL + 1);
  localparam int CNTW = $clog2((TRP > TDPL ? TRP : TDPL) + 1);
  localparam logic [2:0] OP_ACT = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3, OP_MODE = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_AUTO, S_WB, S_PRE} bst_t;

  bst_t             bst  [BANKS];
  logic [CNTW-1:0]  bcnt [BANKS];
  logic [1:0]       bl_code;
  logic [CLW-1:0]   cl;
  logic             wsingle;
  logic             s0_v, s0_wr, s0_ap;
  logic [BW-1:0]    s0_bank;
  logic [ADDR_W-1:0] s0_col;
  logic [2:0]       s0_mask, s0_cnt;
  logic             p_v [MAX_CL-1];
  logic [BW-1:0]    p_b [MAX_CL-1];
  logic [ADDR_W-1:0] p_c [MAX_CL-1];
  logic [2:0]       dq_h;
  logic             pipe_any, rd_busy;

  wire is_rd   = cmd == OP_RD;
  wire is_wr   = cmd == OP_WR;
  wire acc     = is_rd || is_wr;
  wire acc_ok  = acc && bst[cmd_bank] == S_ACT;
  wire act_ok  = cmd == OP_ACT && bst[cmd_bank] == S_IDLE;
  wire [2:0] cl_fld = cmd_addr[6:4];
  wire mode_ok = cmd == OP_MODE && (&bank_idle) && !s0_v && !pipe_any &&
                 cmd_addr[2:0] < 3'd4 && cl_fld != 3'd0 && cl_fld <= 3'(MAX_CL);
  wire flush   = acc_ok && is_wr;
  wire last    = s0_cnt == s0_mask;
  wire release_o = s0_v && s0_ap && (acc_ok || last);
  wire [2:0] rd_mask = 3'((4'd1 << bl_code) - 4'd1);
  wire [ADDR_W-1:0] mext = ADDR_W'(s0_mask);

  assign wr_en   = s0_v && s0_wr;
  assign wr_bank = s0_bank;
  assign wr_col  = s0_col;

  always_comb begin
    pipe_any = 1'b0;
    rd_busy  = s0_v && !s0_wr;
    rd_oe    = s0_v && !s0_wr;
    rd_bank  = s0_bank;
    rd_col   = s0_col;
    for (int i = 0; i < MAX_CL - 1; i++) begin
      pipe_any = pipe_any | p_v[i];
      if (i < int'(cl) - 1) rd_busy = rd_busy | p_v[i];
      if (i == int'(cl) - 2) begin
        rd_oe   = p_v[i];
        rd_bank = p_b[i];
        rd_col  = p_c[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_code <= 2'd0;
      cl      <= CLW'(MAX_CL);
      wsingle <= 1'b0;
      s0_v    <= 1'b0;
      s0_wr   <= 1'b0;
      s0_ap   <= 1'b0;
      s0_bank <= '0;
      s0_col  <= '0;
      s0_mask <= '0;
      s0_cnt  <= '0;
      dq_h    <= '0;
      illegal_cmd    <= 1'b0;
      contention_err <= 1'b0;
    end else begin
      dq_h <= {dq_h[1:0], dqm};
      illegal_cmd <= (cmd == OP_ACT && !act_ok) || (acc && !acc_ok) ||
                     (cmd == OP_MODE && !mode_ok);
      contention_err <= flush && rd_busy && !dq_h[2];
      if (mode_ok) begin
        bl_code <= cmd_addr[1:0];
        cl      <= CLW'(cl_fld);
        wsingle <= cmd_addr[9];
      end
      if (acc_ok) begin
        s0_v    <= 1'b1;
        s0_wr   <= is_wr;
        s0_ap   <= cmd_ap;
        s0_bank <= cmd_bank;
        s0_col  <= cmd_addr;
        s0_mask <= (is_wr && wsingle) ? 3'd0 : rd_mask;
        s0_cnt  <= 3'd0;
      end else if (s0_v) begin
        if (last) s0_v <= 1'b0;
        s0_cnt <= s0_cnt + 3'd1;
        s0_col <= (s0_col & ~mext) | ((s0_col + 1'b1) & mext);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_CL - 1; i++) begin
        p_v[i] <= 1'b0;
        p_b[i] <= '0;
        p_c[i] <= '0;
      end
    end else begin
      p_v[0] <= s0_v && !s0_wr && !flush;
      p_b[0] <= s0_bank;
      p_c[0] <= s0_col;
      for (int i = 1; i < MAX_CL - 1; i++) begin
        p_v[i] <= p_v[i-1] && !flush;
        p_b[i] <= p_b[i-1];
        p_c[i] <= p_c[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_start <= '0;
      for (int i = 0; i < BANKS; i++) begin
        bst[i]  <= S_IDLE;
        bcnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < BANKS; i++) begin
        pre_start[i] <= 1'b0;
        case (bst[i])
          S_IDLE: if (act_ok && cmd_bank == BW'(i)) bst[i] <= S_ACT;
          S_ACT:  if (acc_ok && cmd_ap && cmd_bank == BW'(i)) bst[i] <= S_AUTO;
          S_AUTO: if (release_o && s0_bank == BW'(i)) begin
            if (s0_wr) begin
              bst[i]  <= S_WB;
              bcnt[i] <= CNTW'(TDPL - 1);
            end else begin
              bst[i]       <= S_PRE;
              bcnt[i]      <= CNTW'(TRP - 1);
              pre_start[i] <= 1'b1;
            end
          end
          S_WB: if (bcnt[i] == '0) begin
            bst[i]       <= S_PRE;
            bcnt[i]      <= CNTW'(TRP - 1);
            pre_start[i] <= 1'b1;
          end else bcnt[i] <= bcnt[i] - 1'b1;
          S_PRE: if (bcnt[i] == '0) bst[i] <= S_IDLE;
                 else bcnt[i] <= bcnt[i] - 1'b1;
          default: bst[i] <= S_IDLE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign bank_idle[g] = bst[g] == S_IDLE;
    assign wb_busy[g]   = bst[g] == S_WB;

    AST_PRE_PULSE_IN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start[g] |-> bst[g] == S_PRE); // R12
    AST_IDLE_ONLY_FROM_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_idle[g]) |-> $past(bst[g]) == S_PRE); // R12
    AST_WB_ENDS_IN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wb_busy[g]) |-> pre_start[g]); // R11
  end

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_oe && wr_en)); // R8
  AST_CONTENTION_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    contention_err |-> wr_en); // R9
endmodule

// File: tb/test_sdram_burst_engine.sv
module test_sdram_burst_engine;
  localparam int AW = 10, TRP = 3, TDPL = 2;
  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, MODE = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = 0;
  logic [AW-1:0] addr = 0;
  logic ap = 0, dqm = 0;
  logic rd_oe, wr_en, contention_err, illegal_cmd;
  logic [1:0] rd_bank, wr_bank;
  logic [AW-1:0] rd_col, wr_col;
  logic [3:0] pre_start, wb_busy, bank_idle;
  int checks = 0, errors = 0;

  sdram_burst_engine #(.BANKS(4), .ADDR_W(AW), .MAX_CL(3), .TRP(TRP), .TDPL(TDPL)) i_sdram_burst_engine (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(bank), .cmd_addr(addr), .cmd_ap(ap), .dqm(dqm),
    .rd_oe(rd_oe), .rd_bank(rd_bank), .rd_col(rd_col), .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col),
    .pre_start(pre_start), .wb_busy(wb_busy), .bank_idle(bank_idle),
    .contention_err(contention_err), .illegal_cmd(illegal_cmd));

  always #10 clk = ~clk;

  task automatic eq(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] c, input int b, input int a, input bit p);
    cmd = c; bank = 2'(b); addr = AW'(a); ap = p;
    step();
    cmd = NOP; ap = 0;
  endtask

  function automatic int wrapc(int base, int i, int len);
    return (base & ~(len - 1) & 1023) | ((base + i) & (len - 1));
  endfunction

  function automatic int mword(int code, int cl, bit ws);
    return code | (cl << 4) | (int'(ws) << 9);
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 60; i++) begin
      if (bank_idle == 4'hF) break;
      step();
    end
    eq("R12 all banks idle", int'(bank_idle), 15);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int code, cl, b, col, L, Lw, tmax, cnt;
    bit ws, wr, on;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    eq("R1 bank_idle", int'(bank_idle), 15);
    eq("R1 rd_oe", int'(rd_oe), 0);
    eq("R1 wr_en", int'(wr_en), 0);
    eq("R1 flags", int'(illegal_cmd | contention_err), 0);

    // R2 read to idle bank ignored
    issue(RD, 0, 5, 0);
    eq("R2 illegal read", int'(illegal_cmd), 1);
    for (int t = 0; t < 4; t++) begin
      step();
      eq("R2 ignored read gives no beat", int'(rd_oe), 0);
    end

    // R3 mode field checks
    issue(MODE, 0, mword(5, 3, 0), 0);
    eq("R3 bad length code", int'(illegal_cmd), 1);
    issue(MODE, 0, mword(2, 0, 0), 0);
    eq("R3 bad latency", int'(illegal_cmd), 1);
    issue(MODE, 0, mword(2, 3, 0), 0);
    eq("R3 good mode", int'(illegal_cmd), 0);

    issue(ACT, 0, 0, 0);
    eq("R2 activate", int'(bank_idle[0]), 0);
    eq("R2 activate legal", int'(illegal_cmd), 0);
    issue(ACT, 0, 0, 0);
    eq("R2 double activate", int'(illegal_cmd), 1);
    issue(MODE, 0, mword(1, 2, 0), 0);
    eq("R3 mode with active bank", int'(illegal_cmd), 1);

    // R7 read interrupts read, CL3 BL4
    issue(ACT, 1, 0, 0);
    issue(RD, 0, 'h10, 1);
    eq("R7 first read legal", int'(illegal_cmd), 0);
    eq("R4 no data at t0", int'(rd_oe), 0);
    step();
    eq("R4 no data at t1", int'(rd_oe), 0);
    issue(RD, 1, 'h26, 1);
    eq("R7 t2 oe", int'(rd_oe), 1);
    eq("R7 t2 col", int'(rd_col), 'h10);
    eq("R7 t2 bank", int'(rd_bank), 0);
    eq("R7 precharge at interrupt", int'(pre_start[0]), 1);
    step();
    eq("R7 t3 col", int'(rd_col), 'h11);
    step();
    eq("R7 t4 seamless bank", int'(rd_bank), 1);
    eq("R5 t4 col", int'(rd_col), 'h26);
    step();
    eq("R5 t5 col", int'(rd_col), 'h27);
    step();
    eq("R5 t6 wrap", int'(rd_col), 'h24);
    eq("R10 precharge after burst", int'(pre_start[1]), 1);
    step();
    eq("R5 t7 col", int'(rd_col), 'h25);
    step();
    eq("R4 burst over", int'(rd_oe), 0);
    wait_idle();

    // R8 / R9 write interrupts read without mask
    issue(ACT, 0, 0, 0);
    issue(ACT, 1, 0, 0);
    dqm = 0;
    issue(RD, 0, 'h40, 1);
    step();
    step();
    eq("R8 read data before write", int'(rd_col), 'h40);
    issue(WR, 1, 'h80, 0);
    eq("R9 contention flagged", int'(contention_err), 1);
    eq("R8 read output dropped", int'(rd_oe), 0);
    eq("R8 precharge at write", int'(pre_start[0]), 1);
    eq("R6 write beat", int'(wr_en), 1);
    eq("R6 write col", int'(wr_col), 'h80);
    repeat (8) step();
    eq("R12 bank0 idle again", int'(bank_idle[0]), 1);

    // R9 with mask raised three edges before
    issue(ACT, 0, 0, 0);
    dqm = 1;
    issue(RD, 0, 'h40, 1);
    step();
    step();
    issue(WR, 1, 'h81, 1);
    dqm = 0;
    eq("R9 masked turnaround", int'(contention_err), 0);
    eq("R8 precharge at write", int'(pre_start[0]), 1);
    eq("R5 write col 0", int'(wr_col), 'h81);
    step();
    eq("R5 write col 1", int'(wr_col), 'h82);
    step();
    eq("R5 write col 2", int'(wr_col), 'h83);
    step();
    eq("R5 write wrap", int'(wr_col), 'h80);
    wait_idle();

    issue(ACT, 3, 0, 0);
    issue(WR, 3, 0, 1);
    eq("R9 no read pending", int'(contention_err), 0);
    wait_idle();

    // R13 locked bank
    issue(ACT, 2, 0, 0);
    issue(RD, 2, 'h100, 1);
    issue(RD, 2, 'h200, 0);
    eq("R13 access to committed bank", int'(illegal_cmd), 1);
    for (int t = 2; t <= 5; t++) begin
      step();
      eq("R13 burst unchanged oe", int'(rd_oe), 1);
      eq("R13 burst unchanged col", int'(rd_col), 'h100 + t - 2);
      eq("R13 precharge time", int'(pre_start[2]), int'(t == 4));
    end
    issue(ACT, 2, 0, 0);
    eq("R13 activate while precharging", int'(illegal_cmd), 1);
    step();
    eq("R13 bank idle, activate ignored", int'(bank_idle[2]), 1);
    wait_idle();

    // R6 / R4 single-write mode
    issue(MODE, 0, mword(3, 2, 1), 0);
    issue(ACT, 0, 0, 0);
    issue(WR, 0, 3, 1);
    eq("R6 single write beat", int'(wr_en), 1);
    step();
    eq("R6 single write ends", int'(wr_en), 0);
    eq("R11 write-back", int'(wb_busy[0]), 1);
    wait_idle();
    issue(ACT, 0, 0, 0);
    issue(RD, 0, 5, 1);
    cnt = 0;
    for (int t = 0; t < 14; t++) begin
      cnt += int'(rd_oe);
      step();
    end
    eq("R4 read keeps length 8", cnt, 8);
    wait_idle();

    // random bursts
    for (int it = 0; it < 24; it++) begin
      code = $urandom % 4; cl = 1 + $urandom % 3; b = $urandom % 4;
      col = $urandom % 1024; ws = 1'($urandom % 2); wr = 1'($urandom % 2);
      L = 1 << code; Lw = ws ? 1 : L;
      issue(MODE, 0, mword(code, cl, ws), 0);
      eq("R3 random mode", int'(illegal_cmd), 0);
      issue(ACT, b, 0, 0);
      if (!wr) begin
        issue(RD, b, col, 1);
        tmax = (cl - 1 + L > L + TRP) ? cl - 1 + L : L + TRP;
        for (int t = 0; t <= tmax; t++) begin
          on = t >= cl - 1 && t < cl - 1 + L;
          eq("R4 rd_oe", int'(rd_oe), int'(on));
          if (on) begin
            eq("R5 rd_col", int'(rd_col), wrapc(col, t - cl + 1, L));
            eq("R4 rd_bank", int'(rd_bank), b);
          end
          eq("R10 pre_start", int'(pre_start[b]), int'(t == L));
          eq("R12 bank_idle", int'(bank_idle[b]), int'(t >= L + TRP));
          step();
        end
      end else begin
        issue(WR, b, col, 1);
        tmax = Lw + TDPL + TRP;
        for (int t = 0; t <= tmax; t++) begin
          on = t < Lw;
          eq("R6 wr_en", int'(wr_en), int'(on));
          if (on) eq("R5 wr_col", int'(wr_col), wrapc(col, t, Lw));
          eq("R11 wb_busy", int'(wb_busy[b]), int'(t >= Lw && t < Lw + TDPL));
          eq("R11 pre_start", int'(pre_start[b]), int'(t == Lw + TDPL));
          eq("R12 bank_idle", int'(bank_idle[b]), int'(t >= Lw + TDPL + TRP));
          step();
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule